// File: doc/BRIEF.md
# Sub-Block Valid Direct-Mapped Read Cache

This block is a direct-mapped read cache whose lines each carry one address tag but are split into several sub-blocks, and every sub-block has a separate valid flag. A read hits only when the stored tag equals the address tag and the addressed sub-block is flagged valid. On any miss the cache asks the next memory level for that one sub-block alone, not the whole line. This keeps the transfer on a miss short while still sharing one tag across the line.

A read is accepted from the processor port when `rd_ready` is high. The lookup happens in the following cycle. A hit answers from the data array. A miss raises a sub-block fill request and holds it until the fill arrives. The requested word is then returned straight from the arriving fill data, and the sub-block is installed at the same time. If the tag differs, the line is reallocated first: the new tag is written and all of its sub-block flags are cleared. An invalidate input clears every valid flag in the cache in one cycle.

Default geometry: 16 lines, 4 sub-blocks per line, and 2 words of 32 bits per sub-block, with byte addressing.

Top module: `subblk_cache`

## Requirements
- R1: After a synchronous reset, `rd_ready` is 1, `rsp_valid` and `fill_req_valid` are 0, and every sub-block is invalid, so the first read of any address misses.
- R2: If a read is accepted at clock edge k and hits, `rsp_valid` is high for exactly one cycle after edge k+1 with the addressed word, and no fill request is raised.
- R3: Address fields are as follows: bits [1:0] are the byte offset, bit [2] selects the word inside the sub-block, bits [4:3] select the sub-block, bits [8:5] select the line, and bits [31:9] form the tag. Addresses that differ only in the line field use separate lines.
- R4: If the tag matches but the addressed sub-block is invalid, the read is a miss. The fill request address is the read address with bits [2:0] cleared. The line's other valid sub-blocks stay valid.
- R5: A fill carries one sub-block on `fill_rsp_data`, with word 0 in bits [31:0] and word 1 in bits [63:32]. The response with the requested word follows in the cycle after `fill_rsp_valid` is sampled, and the sub-block then hits on later reads.
- R6: If the tag does not match, the line takes the new tag and all of its sub-block flags are cleared before the fetched sub-block is installed. Sub-blocks that were valid under the old tag then miss.
- R7: `fill_req_valid` rises in the cycle after the missing lookup. It stays high with a stable `fill_req_addr` until `fill_rsp_valid` is sampled, and it drops at that edge.
- R8: `rd_ready` is low from acceptance until the response. A read presented while `rd_ready` is low is ignored.
- R9: A one-cycle pulse on `flush` clears all valid flags, so every line misses afterwards.
- R10: If `flush` and `fill_rsp_valid` are sampled at the same edge, the requester still gets the fill data, but the sub-block is left invalid.
- R11: A `fill_rsp_valid` pulse while no fill is pending produces no response and changes no cached contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate every sub-block |
| rd_valid | input | 1 | Read request present |
| rd_addr | input | 32 | Read byte address |
| rd_ready | output | 1 | Cache can accept a read |
| rsp_valid | output | 1 | Read data valid, one-cycle pulse |
| rsp_data | output | 32 | Read data word |
| fill_req_valid | output | 1 | Sub-block fetch request to next level |
| fill_req_addr | output | 32 | Sub-block aligned fetch address |
| fill_rsp_valid | input | 1 | Fetched sub-block present |
| fill_rsp_data | input | 64 | Fetched sub-block contents |

## Verification
The two functions that can meet in one cycle are the completion of a sub-block fill and a global invalidate. The bench provokes this by driving `flush` high in the same cycle as `fill_rsp_valid` while a miss is pending. It then checks that the response still carries the fetched word, and that a repeat read of the same address misses and issues a new fill request. A stray fill pulse in idle and a read offered while busy are also aimed at the control state, and each is judged by the port behaviour that follows.

// File: rtl/subblk_cache_pkg.sv
package subblk_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_MISS = 2'd2
  } ctrl_state_e;
endpackage

// File: rtl/subblk_tag_store.sv
module subblk_tag_store #(
  parameter int LINES  = 16,
  parameter int SUBS   = 4,
  parameter int TAG_W  = 23,
  localparam int IDX_W = $clog2(LINES),
  localparam int SEL_W = $clog2(SUBS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [IDX_W-1:0] idx,
  input  logic [SEL_W-1:0] sub,
  input  logic [TAG_W-1:0] tag,
  input  logic             alloc_en,
  input  logic             set_en,
  output logic             tag_match,
  output logic             sub_hit
);
  logic [TAG_W-1:0] tag_q [LINES];
  logic [SUBS-1:0]  vld_q [LINES];
  logic             vld_any;

  // tag array: written only when a line is reallocated
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
    end else if (alloc_en) begin
      tag_q[idx] <= tag;
    end
  end

  // valid flags: invalidate beats everything, then reallocation, then fill
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int i = 0; i < LINES; i++) vld_q[i] <= '0;
    end else begin
      if (alloc_en) vld_q[idx] <= '0;
      if (set_en)   vld_q[idx][sub] <= 1'b1;
    end
  end

  always_comb begin
    tag_match = (tag_q[idx] == tag);
    sub_hit   = tag_match && vld_q[idx][sub];
  end

  always_comb begin
    vld_any = 1'b0;
    for (int i = 0; i < LINES; i++) vld_any = vld_any | (|vld_q[i]);
  end

  // R9: an invalidate leaves no valid flag anywhere
  p_flush_clears_r9: assert property (@(posedge clk) disable iff (rst)
    flush |=> !vld_any);

  // R6: reallocation installs the tag and empties the line
  p_alloc_empties_r6: assert property (@(posedge clk) disable iff (rst)
    (alloc_en && !flush) |=> (vld_q[$past(idx)] == '0) && (tag_q[$past(idx)] == $past(tag)));

  // R5: an installed sub-block is valid afterwards
  p_fill_marks_r5: assert property (@(posedge clk) disable iff (rst)
    (set_en && !flush) |=> vld_q[$past(idx)][$past(sub)]);

  // R10: a fill racing an invalidate is not marked valid
  p_flush_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (set_en && flush) |=> !vld_q[$past(idx)][$past(sub)]);
endmodule

// File: rtl/subblk_data_ram.sv
module subblk_data_ram #(
  parameter int DEPTH  = 64,
  parameter int WIDTH  = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data
);
  logic [WIDTH-1:0] mem [DEPTH];

  // simple dual-port, synchronous read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/subblk_ctrl.sv
module subblk_ctrl
  import subblk_cache_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int WORD_W    = 32,
  parameter int SUB_WORDS = 2,
  parameter int WSEL_LSB  = 2,
  localparam int SUB_W     = WORD_W * SUB_WORDS,
  localparam int WSEL_W    = (SUB_WORDS > 1) ? $clog2(SUB_WORDS) : 1,
  localparam int SUB_BYTES = SUB_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_ready,
  output logic              accept,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              tag_match,
  input  logic              sub_hit,
  input  logic [SUB_W-1:0]  ram_q,
  output logic              alloc_en,
  output logic              install_en,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data,
  output logic              fill_req_valid,
  output logic [ADDR_W-1:0] fill_req_addr,
  input  logic              fill_rsp_valid,
  input  logic [SUB_W-1:0]  fill_rsp_data
);
  ctrl_state_e      state_q;
  logic [WSEL_W-1:0] wsel;

  assign wsel          = (SUB_WORDS > 1) ? req_addr[WSEL_LSB +: WSEL_W] : '0;
  assign rd_ready      = (state_q == ST_IDLE);
  assign accept        = rd_valid && rd_ready;
  assign alloc_en      = (state_q == ST_LOOK) && !tag_match;
  assign install_en    = (state_q == ST_MISS) && fill_rsp_valid;
  assign fill_req_addr = req_addr & ~(ADDR_W'(SUB_BYTES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= ST_IDLE;
      req_addr       <= '0;
      rsp_valid      <= 1'b0;
      rsp_data       <= '0;
      fill_req_valid <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            req_addr <= rd_addr;
            state_q  <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (sub_hit) begin
            rsp_valid <= 1'b1;
            rsp_data  <= ram_q[wsel*WORD_W +: WORD_W];
            state_q   <= ST_IDLE;
          end else begin
            fill_req_valid <= 1'b1;
            state_q        <= ST_MISS;
          end
        end
        ST_MISS: begin
          if (fill_rsp_valid) begin
            fill_req_valid <= 1'b0;
            rsp_valid      <= 1'b1;
            rsp_data       <= fill_rsp_data[wsel*WORD_W +: WORD_W];
            state_q        <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: a hit answers next cycle without touching the next level
  p_hit_answers_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOOK && sub_hit) |=> rsp_valid && !fill_req_valid);

  // R2: responses are single-cycle pulses
  p_rsp_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R7: a pending fill request is held steady until served
  p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (fill_req_valid && !fill_rsp_valid) |=> fill_req_valid && $stable(fill_req_addr));

  // R8: no new read accepted right after one was taken
  p_busy_r8: assert property (@(posedge clk) disable iff (rst)
    accept |=> !rd_ready);

  // R11: a fill pulse with nothing pending yields no response
  p_stray_fill_r11: assert property (@(posedge clk) disable iff (rst)
    (fill_rsp_valid && state_q == ST_IDLE) |=> !rsp_valid);
endmodule

// File: rtl/subblk_cache.sv
module subblk_cache #(
  parameter int ADDR_W    = 32,
  parameter int WORD_W    = 32,
  parameter int LINES     = 16,
  parameter int SUBS      = 4,
  parameter int SUB_WORDS = 2,
  localparam int SUB_W    = WORD_W * SUB_WORDS,
  localparam int BOFS_W   = $clog2(WORD_W / 8),
  localparam int WSEL_W   = $clog2(SUB_WORDS),
  localparam int SEL_W    = $clog2(SUBS),
  localparam int IDX_W    = $clog2(LINES),
  localparam int SSEL_LSB = BOFS_W + WSEL_W,
  localparam int IDX_LSB  = SSEL_LSB + SEL_W,
  localparam int TAG_LSB  = IDX_LSB + IDX_W,
  localparam int TAG_W    = ADDR_W - TAG_LSB,
  localparam int DEPTH    = LINES * SUBS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_ready,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data,
  output logic              fill_req_valid,
  output logic [ADDR_W-1:0] fill_req_addr,
  input  logic              fill_rsp_valid,
  input  logic [SUB_W-1:0]  fill_rsp_data
);
  logic              accept;
  logic [ADDR_W-1:0] req_addr;
  logic              tag_match;
  logic              sub_hit;
  logic              alloc_en;
  logic              install_en;
  logic [SUB_W-1:0]  ram_q;
  logic [IDX_W-1:0]  req_idx;
  logic [SEL_W-1:0]  req_sub;
  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W+SEL_W-1:0] ram_rd_addr;
  logic [IDX_W+SEL_W-1:0] ram_wr_addr;

  assign req_idx     = req_addr[IDX_LSB +: IDX_W];
  assign req_sub     = req_addr[SSEL_LSB +: SEL_W];
  assign req_tag     = req_addr[TAG_LSB +: TAG_W];
  assign ram_rd_addr = {rd_addr[IDX_LSB +: IDX_W], rd_addr[SSEL_LSB +: SEL_W]};
  assign ram_wr_addr = {req_idx, req_sub};

  subblk_ctrl #(
    .ADDR_W    (ADDR_W),
    .WORD_W    (WORD_W),
    .SUB_WORDS (SUB_WORDS),
    .WSEL_LSB  (BOFS_W)
  ) u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .rd_valid       (rd_valid),
    .rd_addr        (rd_addr),
    .rd_ready       (rd_ready),
    .accept         (accept),
    .req_addr       (req_addr),
    .tag_match      (tag_match),
    .sub_hit        (sub_hit),
    .ram_q          (ram_q),
    .alloc_en       (alloc_en),
    .install_en     (install_en),
    .rsp_valid      (rsp_valid),
    .rsp_data       (rsp_data),
    .fill_req_valid (fill_req_valid),
    .fill_req_addr  (fill_req_addr),
    .fill_rsp_valid (fill_rsp_valid),
    .fill_rsp_data  (fill_rsp_data)
  );

  subblk_tag_store #(
    .LINES (LINES),
    .SUBS  (SUBS),
    .TAG_W (TAG_W)
  ) u_tags (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .idx       (req_idx),
    .sub       (req_sub),
    .tag       (req_tag),
    .alloc_en  (alloc_en),
    .set_en    (install_en),
    .tag_match (tag_match),
    .sub_hit   (sub_hit)
  );

  subblk_data_ram #(
    .DEPTH (DEPTH),
    .WIDTH (SUB_W)
  ) u_data (
    .clk     (clk),
    .rd_en   (accept),
    .rd_addr (ram_rd_addr),
    .rd_data (ram_q),
    .wr_en   (install_en),
    .wr_addr (ram_wr_addr),
    .wr_data (fill_rsp_data)
  );

  // R4: the fetch address is always sub-block aligned
  p_fill_aligned_r4: assert property (@(posedge clk) disable iff (rst)
    fill_req_valid |-> (fill_req_addr[SSEL_LSB-1:0] == '0));

  // R7: the request drops once the fill is taken
  p_req_drops_r7: assert property (@(posedge clk) disable iff (rst)
    (fill_req_valid && fill_rsp_valid) |=> !fill_req_valid && rsp_valid);
endmodule

// File: tb/subblk_cache_tb.sv
module subblk_cache_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        rd_valid = 1'b0;
  logic [31:0] rd_addr = '0;
  logic        rd_ready;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        fill_req_valid;
  logic [31:0] fill_req_addr;
  logic        fill_rsp_valid = 1'b0;
  logic [63:0] fill_rsp_data = '0;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  subblk_cache u_dut (
    .clk(clk), .rst(rst), .flush(flush),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .fill_req_valid(fill_req_valid), .fill_req_addr(fill_req_addr),
    .fill_rsp_valid(fill_rsp_valid), .fill_rsp_data(fill_rsp_data)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] w;
    w = {a[31:2], 2'b00};
    return (w * 32'h9E37_79B1) ^ 32'h1234_5678;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // one read; a miss is served by a model of the next level
  task automatic do_read(input logic [31:0] a, input bit exp_hit, input string rq,
                         input bit flush_on_fill = 1'b0, input int stall = 0);
    logic [31:0] base;
    base = {a[31:3], 3'b000};
    @(negedge clk);
    chk(rd_ready == 1'b1, {rq, " ready before read"}, 64'(rd_ready), 64'd1);
    rd_valid = 1'b1;
    rd_addr  = a;
    @(negedge clk);
    rd_valid = 1'b0;
    chk(rd_ready == 1'b0, {rq, " R8 busy after accept"}, 64'(rd_ready), 64'd0);
    @(negedge clk);
    if (exp_hit) begin
      chk(rsp_valid == 1'b1, {rq, " R2 hit response"}, 64'(rsp_valid), 64'd1);
      chk(fill_req_valid == 1'b0, {rq, " R2 no fill on hit"}, 64'(fill_req_valid), 64'd0);
      chk(rsp_data == mem_word(a), {rq, " R2 hit data"}, 64'(rsp_data), 64'(mem_word(a)));
      @(negedge clk);
      chk(rsp_valid == 1'b0, {rq, " R2 single pulse"}, 64'(rsp_valid), 64'd0);
    end else begin
      chk(fill_req_valid == 1'b1 && rsp_valid == 1'b0, {rq, " R7 miss raises fill"},
          64'(fill_req_valid), 64'd1);
      chk(fill_req_addr == base, {rq, " R4 fill address"}, 64'(fill_req_addr), 64'(base));
      for (int i = 0; i < stall; i++) begin
        rd_valid = 1'b1;
        rd_addr  = a ^ 32'h0000_0100;
        @(negedge clk);
        chk(fill_req_valid == 1'b1 && fill_req_addr == base, {rq, " R7 request held"},
            64'(fill_req_addr), 64'(base));
        chk(rd_ready == 1'b0 && rsp_valid == 1'b0, {rq, " R8 read ignored while busy"},
            64'({rd_ready, rsp_valid}), 64'd0);
      end
      rd_valid       = 1'b0;
      fill_rsp_valid = 1'b1;
      fill_rsp_data  = {mem_word(base + 32'd4), mem_word(base)};
      flush          = flush_on_fill;
      @(negedge clk);
      fill_rsp_valid = 1'b0;
      flush          = 1'b0;
      chk(rsp_valid == 1'b1 && rsp_data == mem_word(a), {rq, " R5 fill response"},
          64'(rsp_data), 64'(mem_word(a)));
      chk(fill_req_valid == 1'b0, {rq, " R7 request dropped"}, 64'(fill_req_valid), 64'd0);
      @(negedge clk);
    end
    chk(rd_ready == 1'b1, {rq, " R8 ready after response"}, 64'(rd_ready), 64'd1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(rd_ready == 1'b1, "R1 ready after reset", 64'(rd_ready), 64'd1);
    chk(rsp_valid == 1'b0 && fill_req_valid == 1'b0, "R1 outputs idle after reset",
        64'({rsp_valid, fill_req_valid}), 64'd0);
    do_read(32'h0000_0000, 1'b0, "R1 first read misses");
  endtask

  task automatic t_sub_blocks();
    // line 2, tag 5: sub 0 then sub 2
    do_read(32'h0000_0A40, 1'b0, "R4 sub0 compulsory");
    do_read(32'h0000_0A44, 1'b1, "R3 word1 of same sub-block");
    do_read(32'h0000_0A50, 1'b0, "R4 sub2 misses under matching tag");
    do_read(32'h0000_0A40, 1'b1, "R4 sub0 kept valid");
    do_read(32'h0000_0A54, 1'b1, "R5 installed sub2 hits");
  endtask

  task automatic t_tag_replace();
    do_read(32'h0000_1A48, 1'b0, "R6 other tag same line");
    do_read(32'h0000_1A48, 1'b1, "R6 new tag installed");
    do_read(32'h0000_0A40, 1'b0, "R6 old sub0 gone");
    do_read(32'h0000_1A48, 1'b0, "R6 replaced again");
  endtask

  task automatic t_decode();
    do_read(32'h0000_00B8, 1'b0, "R3 line 5 fill");
    do_read(32'h0000_00D8, 1'b0, "R3 line 6 separate");
    do_read(32'h0000_00BC, 1'b1, "R3 line 5 still hits");
  endtask

  task automatic t_hold();
    do_read(32'h0000_2128, 1'b0, "R7 stalled fill", 1'b0, 3);
    do_read(32'h0000_212C, 1'b1, "R8 stalled fill installed");
    do_read(32'h0000_2028, 1'b0, "R8 ignored address not cached");
  endtask

  task automatic t_flush();
    do_read(32'h0000_3300, 1'b0, "R9 setup a");
    do_read(32'h0000_3318, 1'b0, "R9 setup b");
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    do_read(32'h0000_3300, 1'b0, "R9 line a flushed");
    do_read(32'h0000_3318, 1'b0, "R9 line b flushed");
  endtask

  task automatic t_collision();
    do_read(32'h0000_4564, 1'b0, "R10 fill with flush", 1'b1);
    do_read(32'h0000_4564, 1'b0, "R10 not marked valid");
    do_read(32'h0000_4560, 1'b1, "R10 later fill valid");
  endtask

  task automatic t_stray();
    do_read(32'h0000_5070, 1'b0, "R11 setup");
    @(negedge clk);
    fill_rsp_valid = 1'b1;
    fill_rsp_data  = 64'hDEAD_BEEF_0BAD_F00D;
    @(negedge clk);
    fill_rsp_valid = 1'b0;
    chk(rsp_valid == 1'b0 && fill_req_valid == 1'b0, "R11 stray fill no response",
        64'({rsp_valid, fill_req_valid}), 64'd0);
    do_read(32'h0000_5070, 1'b1, "R11 cached data untouched");
    do_read(32'h0000_5074, 1'b1, "R11 cached word1 untouched");
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_sub_blocks();
    t_tag_replace();
    t_decode();
    t_hold();
    t_flush();
    t_collision();
    t_stray();
    repeat (2) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule